// File: doc/BRIEF.md
# Indexed Register Access Port with Auto-Increment

This block is a host-side register window that is reached through a single data bus and a data/command select line. A write with the select line low is a command: it loads an 8-bit register index. A write with the select line high stores data into the register named by that index, after which the index moves on by two so that a host can write a run of consecutive registers without issuing a new command. Three register positions act as streaming ports and keep the index in place, so a host can push a long burst into one of them. A read with the select line high returns the indexed register and moves the index on by one.

Behind the window sit an identification constant, a 10-bit value held in a low-byte and a high-byte register, two indirectly addressed tables (a 32-entry table that stops at its end and a 256-entry table that wraps), and an interrupt status register. Hardware events set status bits; the host clears them by writing a mask that is ANDed into the status.

Top module: `idx_reg_port`

## Requirements
- R1: A write with dc_sel low loads the register index from wr_data[7:0]; any upper data bits are ignored.
- R2: A write with dc_sel high adds 2 to the index (modulo 256); a read with dc_sel high adds 1; a read with dc_sel low leaves the index unchanged. When wr_en and rd_en are both high the read is ignored.
- R3: A data write leaves the index unchanged when the index is 0x5A, 0x90 or 0xB8 (the streaming ports).
- R4: The 10-bit value (span_o, reset value 0x001) takes bits 7:0 from a data write at index 0x10 and bits 9:8 from wr_data[1:0] on a data write at index 0x12, each write keeping the other bits; reads return span_o[7:0] at 0x10 and span_o[9:8] in bits 1:0 at 0x12.
- R5: Index 0x58 holds the 32-entry table pointer: a write loads it from wr_data[4:0], a read returns it. Each data write or data read (dc_sel high) at 0x5A accesses the entry at the pointer and then increments the pointer.
- R6: When the 32-entry table pointer equals 0x20, writes at 0x5A are ignored, reads there return 0 and the pointer stays at 0x20.
- R7: Index 0xB6 holds the 256-entry table pointer (8 bits, loaded from wr_data[7:0]); accesses at 0xB8 read or write the pointed entry and post-increment it, wrapping from 0xFF to 0x00.
- R8: The 8-bit interrupt status at index 0xF6 ORs in irq_set every cycle; a data write there ANDs wr_data[7:0] into the status, and a bit set by irq_set in the same cycle survives the write. irq_o is high when any status bit is set.
- R9: Reads at index 0x00 return 0xA5; writes there have no effect.
- R10: Writes at any other index have no effect and reads there return 0; bits 15:8 of rd_data are always 0.
- R11: A synchronous reset sets the index to 0, both table pointers to 0, the status to 0 and the 10-bit value to 0x001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one access per cycle |
| rd_en | input | 1 | Host read strobe, one access per cycle |
| dc_sel | input | 1 | Low: command (index) access; high: data access |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Contents of the indexed register, valid in the cycle of the read |
| irq_set | input | 8 | Interrupt event bits, ORed into the status each cycle |
| irq_o | output | 1 | High when any status bit is set |
| span_o | output | 10 | Current 10-bit split value |

## Verification
The two functions that can coincide are a hardware event on irq_set and a host write-AND clear of the status register in the same clock cycle. The bench provokes this directly by clearing the status with a zero mask while raising one event bit, expecting that bit to remain set, and the random phase raises events at random during all host accesses including status writes. Each result is judged by reading the status back through the port and by watching irq_o against a model that applies the mask before ORing in the events.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;

   localparam logic [7:0] A_ID      = 8'h00;
   localparam logic [7:0] A_SPAN_LO = 8'h10;
   localparam logic [7:0] A_SPAN_HI = 8'h12;
   localparam logic [7:0] A_TA_PTR  = 8'h58;
   localparam logic [7:0] A_TA_DAT  = 8'h5A;
   localparam logic [7:0] A_SINK    = 8'h90;
   localparam logic [7:0] A_TB_PTR  = 8'hB6;
   localparam logic [7:0] A_TB_DAT  = 8'hB8;
   localparam logic [7:0] A_IRQ     = 8'hF6;

   localparam logic [7:0] ID_VALUE  = 8'hA5;

   // Positions where a data write keeps the index in place
   function automatic logic is_stream(input logic [7:0] a);
      return (a == A_TA_DAT) || (a == A_SINK) || (a == A_TB_DAT);
   endfunction

   // Host access kinds decoded from the strobes
   typedef struct packed {
      logic cmd_wr;
      logic dat_wr;
      logic dat_rd;
   } host_acc_t;

endpackage

// File: rtl/idx_seq.sv
module idx_seq
   import idx_port_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  host_acc_t acc,
   input  logic [7:0] cmd_val,
   output logic [7:0] cur_idx
);

   logic [7:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst)
         idx_q <= 8'h00;
      else if (acc.cmd_wr)
         idx_q <= cmd_val;
      else if (acc.dat_wr && !is_stream(idx_q))
         idx_q <= idx_q + 8'd2;
      else if (acc.dat_rd)
         idx_q <= idx_q + 8'd1;
   end

   assign cur_idx = idx_q;

endmodule

// File: rtl/split_reg.sv
module split_reg #(
   parameter int         VAL_W   = 10,
   parameter logic [15:0] RST_VAL = 16'h0001
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       lo_in,
   input  logic [VAL_W-9:0] hi_in,
   output logic [VAL_W-1:0] val_o
);

   localparam int HI_W = VAL_W - 8;

   if (VAL_W < 9 || VAL_W > 16) begin : g_bad_width
      $error("split_reg: VAL_W must lie in 9..16");
   end

   logic [7:0]      lo_q;
   logic [HI_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q <= RST_VAL[7:0];
         hi_q <= RST_VAL[VAL_W-1:8];
      end else begin
         if (wr_lo) lo_q <= lo_in;
         if (wr_hi) hi_q <= hi_in;
      end
   end

   assign val_o = {hi_q, lo_q};

endmodule

// File: rtl/ptr_table.sv
module ptr_table #(
   parameter int DEPTH    = 32,
   parameter int ENT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ptr_wr,
   input  logic [7:0]       ptr_in,
   input  logic             dat_wr,
   input  logic             dat_rd,
   input  logic [ENT_W-1:0] dat_in,
   output logic [7:0]       ptr_o,
   output logic [ENT_W-1:0] dat_o
);

   localparam int AW    = $clog2(DEPTH);
   localparam int PTR_W = AW + (SATURATE ? 1 : 0);

   if (PTR_W > 8) begin : g_bad_ptr
      $error("ptr_table: pointer does not fit an 8-bit register");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("ptr_table: DEPTH must be a power of two");
   end

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] ptr_q;
   logic             in_rng;
   logic [AW-1:0]    slot;
   logic             unused_ptr_bits;

   assign slot            = ptr_q[AW-1:0];
   assign unused_ptr_bits = ^ptr_in;

   if (SATURATE) begin : g_sat
      // Extra pointer bit marks the end position, which blocks accesses
      assign in_rng = ~ptr_q[PTR_W-1];
   end else begin : g_wrap
      assign in_rng = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ptr_q <= '0;
      else if (ptr_wr)
         ptr_q <= PTR_W'(ptr_in[AW-1:0]);
      else if ((dat_wr || dat_rd) && in_rng)
         ptr_q <= ptr_q + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (dat_wr && in_rng)
         mem[slot] <= dat_in;
   end

   assign ptr_o = 8'(ptr_q);
   assign dat_o = in_rng ? mem[slot] : '0;

endmodule

// File: rtl/irq_status.sv
module irq_status #(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [STAT_W-1:0] set_i,
   input  logic              mask_wr,
   input  logic [STAT_W-1:0] mask_in,
   output logic [STAT_W-1:0] stat_o
);

   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] kept;

   assign kept = mask_wr ? (stat_q & mask_in) : stat_q;

   always_ff @(posedge clk) begin
      if (rst)
         stat_q <= '0;
      else
         stat_q <= kept | set_i;
   end

   assign stat_o = stat_q;

endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
   import idx_port_pkg::*;
#(
   parameter int          DATA_W   = 16,
   parameter int          SPAN_W   = 10,
   parameter logic [15:0] SPAN_RST = 16'h0001,
   parameter int          TA_DEPTH = 32,
   parameter int          TB_DEPTH = 256,
   parameter int          ENT_W    = 8,
   parameter int          IRQ_W    = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              dc_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [IRQ_W-1:0]  irq_set,
   output logic              irq_o,
   output logic [SPAN_W-1:0] span_o
);

   if (DATA_W < 8) begin : g_bad_data
      $error("idx_reg_port: DATA_W must be at least 8");
   end
   if (ENT_W > 8 || IRQ_W > 8) begin : g_bad_byte
      $error("idx_reg_port: table entries and status must fit a byte");
   end

   host_acc_t         acc;
   logic [7:0]        cur_idx;
   logic [7:0]        rd_byte;
   logic [SPAN_W-1:0] span_q;
   logic [7:0]        ta_ptr, tb_ptr;
   logic [ENT_W-1:0]  ta_dat, tb_dat;
   logic [IRQ_W-1:0]  irq_q;
   logic              unused_wr_hi;

   assign acc.cmd_wr = wr_en & ~dc_sel;
   assign acc.dat_wr = wr_en & dc_sel;
   assign acc.dat_rd = rd_en & ~wr_en & dc_sel;

   assign unused_wr_hi = ^wr_data;

   idx_seq u_idx (
      .clk     (clk),
      .rst     (rst),
      .acc     (acc),
      .cmd_val (wr_data[7:0]),
      .cur_idx (cur_idx)
   );

   split_reg #(
      .VAL_W   (SPAN_W),
      .RST_VAL (SPAN_RST)
   ) u_span (
      .clk   (clk),
      .rst   (rst),
      .wr_lo (acc.dat_wr && cur_idx == A_SPAN_LO),
      .wr_hi (acc.dat_wr && cur_idx == A_SPAN_HI),
      .lo_in (wr_data[7:0]),
      .hi_in (wr_data[SPAN_W-9:0]),
      .val_o (span_q)
   );

   ptr_table #(
      .DEPTH    (TA_DEPTH),
      .ENT_W    (ENT_W),
      .SATURATE (1'b1)
   ) u_tbl_a (
      .clk    (clk),
      .rst    (rst),
      .ptr_wr (acc.dat_wr && cur_idx == A_TA_PTR),
      .ptr_in (wr_data[7:0]),
      .dat_wr (acc.dat_wr && cur_idx == A_TA_DAT),
      .dat_rd (acc.dat_rd && cur_idx == A_TA_DAT),
      .dat_in (wr_data[ENT_W-1:0]),
      .ptr_o  (ta_ptr),
      .dat_o  (ta_dat)
   );

   ptr_table #(
      .DEPTH    (TB_DEPTH),
      .ENT_W    (ENT_W),
      .SATURATE (1'b0)
   ) u_tbl_b (
      .clk    (clk),
      .rst    (rst),
      .ptr_wr (acc.dat_wr && cur_idx == A_TB_PTR),
      .ptr_in (wr_data[7:0]),
      .dat_wr (acc.dat_wr && cur_idx == A_TB_DAT),
      .dat_rd (acc.dat_rd && cur_idx == A_TB_DAT),
      .dat_in (wr_data[ENT_W-1:0]),
      .ptr_o  (tb_ptr),
      .dat_o  (tb_dat)
   );

   irq_status #(
      .STAT_W (IRQ_W)
   ) u_irq (
      .clk     (clk),
      .rst     (rst),
      .set_i   (irq_set),
      .mask_wr (acc.dat_wr && cur_idx == A_IRQ),
      .mask_in (wr_data[IRQ_W-1:0]),
      .stat_o  (irq_q)
   );

   always_comb begin
      case (cur_idx)
         A_ID:      rd_byte = ID_VALUE;
         A_SPAN_LO: rd_byte = span_q[7:0];
         A_SPAN_HI: rd_byte = 8'(span_q[SPAN_W-1:8]);
         A_TA_PTR:  rd_byte = ta_ptr;
         A_TA_DAT:  rd_byte = 8'(ta_dat);
         A_TB_PTR:  rd_byte = tb_ptr;
         A_TB_DAT:  rd_byte = 8'(tb_dat);
         A_IRQ:     rd_byte = 8'(irq_q);
         default:   rd_byte = 8'h00;
      endcase
   end

   assign rd_data = DATA_W'(rd_byte);
   assign irq_o   = |irq_q;
   assign span_o  = span_q;

endmodule

// File: rtl/idx_reg_port_chk.sv
module idx_reg_port_chk
   import idx_port_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SPAN_W = 10,
   parameter int IRQ_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              rd_en,
   input logic              dc_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [IRQ_W-1:0]  irq_set,
   input logic              irq_o,
   input logic [SPAN_W-1:0] span_o,
   input logic [7:0]        cur_idx
);

   AST_CMD_LOAD: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !dc_sel) |=> cur_idx == $past(wr_data[7:0])); // R1

   AST_WR_STEP: assert property (@(posedge clk) disable iff (rst)
      (wr_en && dc_sel && !is_stream(cur_idx)) |=> cur_idx == $past(cur_idx) + 8'd2); // R2

   AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !wr_en && dc_sel) |=> cur_idx == $past(cur_idx) + 8'd1); // R2

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !wr_en && !dc_sel) |=> $stable(cur_idx)); // R2

   AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wr_en && dc_sel && is_stream(cur_idx)) |=> $stable(cur_idx)); // R3

   AST_SPAN_LO_KEPT: assert property (@(posedge clk) disable iff (rst)
      (wr_en && dc_sel && cur_idx == A_SPAN_HI) |=> $stable(span_o[7:0])); // R4

   AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (|irq_set) |=> irq_o); // R8

   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (wr_en && dc_sel && cur_idx == A_IRQ && wr_data[7:0] == 8'h00 && irq_set == '0)
      |=> !irq_o); // R8

   AST_ID_CONST: assert property (@(posedge clk) disable iff (rst)
      (cur_idx == A_ID) |-> rd_data == DATA_W'(ID_VALUE)); // R9

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      rd_data[DATA_W-1:8] == '0); // R10

endmodule

bind idx_reg_port idx_reg_port_chk #(
   .DATA_W (DATA_W),
   .SPAN_W (SPAN_W),
   .IRQ_W  (IRQ_W)
) chk_i (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .dc_sel  (dc_sel),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .irq_set (irq_set),
   .irq_o   (irq_o),
   .span_o  (span_o),
   .cur_idx (cur_idx)
);

// File: tb/idx_reg_port_tb_top.sv
module idx_reg_port_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic        dc_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [7:0]  irq_set = '0;
   logic        irq_o;
   logic [9:0]  span_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Requirement-level model
   logic [7:0] m_idx;
   logic [9:0] m_span;
   logic [7:0] m_ta [32];
   logic [5:0] m_pa;
   logic [7:0] m_tb [256];
   logic [7:0] m_pb;
   logic [7:0] m_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_reg_port dut_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .dc_sel  (dc_sel),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .irq_set (irq_set),
      .irq_o   (irq_o),
      .span_o  (span_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd();
      case (m_idx)
         8'h00: return 16'h00A5;
         8'h10: return {8'h00, m_span[7:0]};
         8'h12: return {14'h0, m_span[9:8]};
         8'h58: return {10'h0, m_pa};
         8'h5A: return (m_pa < 6'd32) ? {8'h00, m_ta[m_pa[4:0]]} : 16'h0;
         8'hB6: return {8'h00, m_pb};
         8'hB8: return {8'h00, m_tb[m_pb]};
         8'hF6: return {8'h00, m_irq};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic clk_edge();
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0; irq_set = '0;
   endtask

   task automatic op_cmd(input logic [15:0] v, input logic [7:0] s);
      wr_en = 1'b1; dc_sel = 1'b0; wr_data = v; irq_set = s;
      clk_edge();
      m_idx = v[7:0];
      m_irq = m_irq | s;
   endtask

   task automatic op_wr(input logic [15:0] v, input logic [7:0] s);
      logic [7:0] mk;
      wr_en = 1'b1; dc_sel = 1'b1; wr_data = v; irq_set = s;
      clk_edge();
      mk = 8'hFF;
      case (m_idx)
         8'h10: m_span[7:0] = v[7:0];
         8'h12: m_span[9:8] = v[1:0];
         8'h58: m_pa = {1'b0, v[4:0]};
         8'h5A: if (m_pa < 6'd32) begin m_ta[m_pa[4:0]] = v[7:0]; m_pa++; end
         8'hB6: m_pb = v[7:0];
         8'hB8: begin m_tb[m_pb] = v[7:0]; m_pb++; end
         8'hF6: mk = v[7:0];
         default: ;
      endcase
      m_irq = (m_irq & mk) | s;
      if (m_idx != 8'h5A && m_idx != 8'h90 && m_idx != 8'hB8) m_idx = m_idx + 8'd2;
   endtask

   task automatic op_rd(input logic dc, input logic [7:0] s, input string tag);
      rd_en = 1'b1; dc_sel = dc; irq_set = s;
      #1;
      chk(tag, rd_data, exp_rd());
      clk_edge();
      if (dc) begin
         if (m_idx == 8'h5A && m_pa < 6'd32) m_pa++;
         if (m_idx == 8'hB8) m_pb++;
         m_idx = m_idx + 8'd1;
      end
      m_irq = m_irq | s;
   endtask

   function automatic logic [7:0] pick_idx();
      logic [7:0] lst [10] = '{8'h00, 8'h10, 8'h12, 8'h58, 8'h5A,
                               8'hB6, 8'hB8, 8'hF6, 8'h90, 8'h44};
      return lst[$urandom % 10];
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      m_idx = 8'h00; m_span = 10'h001; m_pa = '0; m_pb = '0; m_irq = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R11: reset state, R9: identity constant, read with dc low holds index (R2)
      chk("R11 span reset", span_o, 10'h001);
      chk("R11 irq reset", irq_o, 1'b0);
      op_rd(1'b0, 8'h00, "R9 id read dc low");
      op_rd(1'b1, 8'h00, "R11 index zero after reset");
      op_rd(1'b1, 8'h00, "R10 unknown index 0x01 reads 0");

      // R9: write to ID ignored
      op_cmd(16'h0000, 8'h00);
      op_wr(16'h005A, 8'h00);
      op_cmd(16'h0000, 8'h00);
      op_rd(1'b1, 8'h00, "R9 id unchanged after write");

      // R1: upper command bits ignored; R4: split value
      op_cmd(16'hAB10, 8'h00);
      op_wr(16'h00FF, 8'h00);
      op_wr(16'hFF06, 8'h00);
      chk("R4 span after lo/hi writes", span_o, 10'h2FF);
      op_cmd(16'h0010, 8'h00);
      op_rd(1'b1, 8'h00, "R4 span low readback");
      op_cmd(16'h0012, 8'h00);
      op_rd(1'b1, 8'h00, "R4 span high readback");
      op_cmd(16'h0012, 8'h00);
      op_wr(16'h0001, 8'h00);
      chk("R4 high write keeps low byte", span_o, 10'h1FF);

      // R2: index wraps modulo 256 after a data write at 0xFE
      op_cmd(16'h00FE, 8'h00);
      op_wr(16'h1234, 8'h00);
      op_rd(1'b1, 8'h00, "R2 index wrapped to 0x00");

      // R10: write at unknown index has no effect
      op_cmd(16'h0044, 8'h00);
      op_wr(16'h00EE, 8'h00);
      op_cmd(16'h0044, 8'h00);
      op_rd(1'b1, 8'h00, "R10 unknown index reads 0");

      // R5/R3: fill table A through the held streaming index
      op_cmd(16'h0058, 8'h00);
      op_wr(16'h0000, 8'h00);
      for (int i = 0; i < 32; i++) op_wr(16'((i * 37 + 5) & 8'hFF), 8'h00);
      // R6: pointer now at end; extra write ignored
      op_wr(16'h0033, 8'h00);
      op_cmd(16'h0058, 8'h00);
      op_rd(1'b1, 8'h00, "R6 pointer stops at 0x20");
      op_cmd(16'h005A, 8'h00);
      op_rd(1'b1, 8'h00, "R6 read at end returns 0");
      op_cmd(16'h0058, 8'h00);
      op_wr(16'h003E, 8'h00);
      op_cmd(16'h0058, 8'h00);
      op_rd(1'b1, 8'h00, "R5 pointer load masked to 5 bits");
      op_cmd(16'h005A, 8'h00);
      op_rd(1'b1, 8'h00, "R5 entry 0x1E");
      op_cmd(16'h005A, 8'h00);
      op_rd(1'b1, 8'h00, "R5 read post-increment entry 0x1F");

      // R7/R3: fill table B and check wrap
      op_cmd(16'h00B6, 8'h00);
      op_wr(16'h0000, 8'h00);
      for (int i = 0; i < 256; i++) op_wr(16'((i * 11 + 3) & 8'hFF), 8'h00);
      op_cmd(16'h00B6, 8'h00);
      op_rd(1'b1, 8'h00, "R7 pointer wrapped to 0x00");
      op_cmd(16'h00B6, 8'h00);
      op_wr(16'h00FF, 8'h00);
      op_wr(16'h0077, 8'h00);
      op_wr(16'h0088, 8'h00);
      op_cmd(16'h00B6, 8'h00);
      op_wr(16'h00FF, 8'h00);
      op_rd(1'b1, 8'h00, "R7 entry 0xFF");
      op_cmd(16'h00B8, 8'h00);
      op_rd(1'b1, 8'h00, "R7 wrapped write to entry 0x00");

      // R8: set, write-AND, set and clear in the same cycle
      op_rd(1'b0, 8'hF0, "R8 idle cycle with events");
      chk("R8 irq after event", irq_o, 1'b1);
      op_cmd(16'h00F6, 8'h00);
      op_wr(16'h003C, 8'h00);
      op_cmd(16'h00F6, 8'h00);
      op_rd(1'b1, 8'h00, "R8 status after AND mask");
      op_cmd(16'h00F6, 8'h00);
      op_wr(16'h0000, 8'h01);
      op_cmd(16'h00F6, 8'h00);
      op_rd(1'b1, 8'h00, "R8 same-cycle event survives clear");
      chk("R8 irq still high", irq_o, 1'b1);
      op_cmd(16'h00F6, 8'h00);
      op_wr(16'h0000, 8'h00);
      chk("R8 irq cleared", irq_o, 1'b0);

      // R2: simultaneous write and read, read ignored
      op_cmd(16'h0010, 8'h00);
      wr_en = 1'b1; rd_en = 1'b1; dc_sel = 1'b1; wr_data = 16'h0042;
      clk_edge();
      m_span[7:0] = 8'h42; m_idx = 8'h12;
      op_rd(1'b1, 8'h00, "R2 read ignored during write");

      // Random phase against the model
      for (int n = 0; n < N_RANDOM; n++) begin
         automatic int r = $urandom % 10;
         automatic logic [7:0] s = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
         if (r < 2)      op_cmd({8'($urandom), pick_idx()}, s);
         else if (r < 5) op_wr(16'($urandom), s);
         else if (r < 8) op_rd(1'b1, s, "R5 R7 R8 R10 random data read");
         else            op_rd(1'b0, s, "R2 random command read");
         chk("R4 random span_o", span_o, m_span);
         chk("R8 random irq_o", irq_o, |m_irq);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule